// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Decode

This unit takes one 32-bit instruction word per cycle, together with two 32-bit source operands and a valid strobe. It recognises a small family of register-register multiply instructions and runs them. All of these instructions share one major opcode and one function code. A five-bit subop field in the shift-amount position picks the operation. It selects a signed or unsigned product, chooses between adding to the 64-bit accumulator and overwriting it, and chooses whether the low or the high half of the new accumulator goes back to the destination register.

The result, the destination index and the write enable come out of a register one cycle after the instruction is presented. The accumulator holds the new value on that same edge, so a following instruction builds on the updated sum. An instruction outside the family raises a one-cycle illegal flag and changes nothing else. Both halves of the accumulator are driven out as read-only outputs.

Top module: `mdu_top`

## Requirements
- R1: While rst_n is low, and after it is released, acc_hi and acc_lo read zero, and wr_en and illegal read zero.
- R2: A valid instruction with bits [31:26]=000000, [5:0]=101000 and subop [10:6]=00100 sets the accumulator to the sign-extended signed product src_a*src_b. Subop 00101 does the same with the zero-extended unsigned product. On the next cycle wr_en=1, wr_idx=instr[15:11] and wr_data is the low 32 bits of the new accumulator.
- R3: Subop 01100 (signed) and subop 01101 (unsigned) overwrite the accumulator with the product. They return the high 32 bits of the new accumulator to rd.
- R4: Subop 00010 (signed) and subop 00011 (unsigned) add the product to the accumulator. They return the low 32 bits of the sum to rd.
- R5: Subop 01010 (signed) and subop 01011 (unsigned) add the product to the accumulator. They return the high 32 bits of the sum to rd.
- R6: Subop 00000 with rd=00000 adds the signed product to the accumulator and leaves wr_en low.
- R7: A valid word is illegal when any of the following holds:
  - the major opcode is wrong;
  - the function code is wrong;
  - the subop is 00000 with rd other than 0;
  - bit 4 of the subop is set;
  - bits 1 and 2 of the subop are equal, apart from the 00000 case above.

  An illegal word raises illegal for exactly the next cycle, keeps wr_en low and leaves the accumulator unchanged.
- R8: Accumulation wraps modulo 2^64 and has no saturation.
- R9: Instructions presented on consecutive cycles take effect in order. Each one sees the sum left by the one before it.
- R10: With in_valid low the accumulator holds its value, and wr_en and illegal read zero on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand (rs value) |
| src_b | input | 32 | Second source operand (rt value) |
| wr_en | output | 1 | Destination write enable, registered |
| wr_idx | output | 5 | Destination register index |
| wr_data | output | 32 | Selected accumulator half |
| illegal | output | 1 | One-cycle flag for an unrecognised word |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
Two things share one clock edge when instructions arrive back to back. The first is the write-back of one instruction's selected half. The second is the accumulator update of the next instruction, which must add onto the sum that was just returned and not onto the older value. Long runs of valid instructions with no gaps provoke this case. They mix overwrite and accumulate, signed and unsigned, low and high return, and they include illegal words placed between accumulates. A behavioural model in the bench updates its own 64-bit sum in program order, and on every cycle it is compared with the write-back and with both accumulator halves.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int unsigned ILEN = 32;
  localparam logic [5:0] MAJOR_SPECIAL = 6'b000000;
  localparam logic [5:0] FUNCT_MULFAM  = 6'b101000;

  typedef struct packed {
    logic legal;
    logic write_rd;
    logic acc_mode;
    logic unsgn;
    logic hi_sel;
  } mdu_op_t;
endpackage

// File: rtl/mdu_decode.sv
module mdu_decode
  import mdu_pkg::*;
#(
  parameter int unsigned IDXW = 5
) (
  input  logic [ILEN-1:0] instr,
  output mdu_op_t         op,
  output logic [IDXW-1:0] rd
);
  logic [4:0] sub;
  logic       fmt_ok;
  logic       silent;
  logic       write_form;
  logic       unused_src_fields;

  assign unused_src_fields = ^instr[25:16];
  assign sub = instr[10:6];
  assign rd  = instr[11 +: IDXW];

  always_comb begin
    fmt_ok      = (instr[31:26] == MAJOR_SPECIAL) && (instr[5:0] == FUNCT_MULFAM);
    silent      = (sub == 5'b00000) && (instr[15:11] == 5'b00000);
    write_form  = !sub[4] && (sub[1] ^ sub[2]);
    op.legal    = fmt_ok && (silent || write_form);
    op.write_rd = write_form;
    op.acc_mode = silent || sub[1];
    op.unsgn    = sub[0];
    op.hi_sel   = sub[3];
  end
endmodule

// File: rtl/mdu_mult.sv
module mdu_mult #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned PW  = 2 * XLEN
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic            unsgn,
  output logic [PW-1:0]   prod
);
  logic signed [XLEN:0]   a_ext;
  logic signed [XLEN:0]   b_ext;
  logic signed [PW+1:0]   full;
  logic [1:0]             unused_top_bits;

  always_comb begin
    a_ext = {(unsgn ? 1'b0 : a[XLEN-1]), a};
    b_ext = {(unsgn ? 1'b0 : b[XLEN-1]), b};
    full  = (PW+2)'(a_ext) * (PW+2)'(b_ext);
  end

  assign prod            = full[PW-1:0];
  assign unused_top_bits = full[PW+1:PW];
endmodule

// File: rtl/mdu_acc.sv
module mdu_acc
  import mdu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5,
  localparam int unsigned AW  = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  mdu_op_t         op,
  input  logic [IDXW-1:0] rd,
  input  logic [AW-1:0]   prod,
  output logic [AW-1:0]   acc,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic            illegal
);
  logic [AW-1:0]   acc_q, acc_d;
  logic            acc_ce;
  logic            wen_d, ill_d;
  logic [XLEN-1:0] wdata_d;

  always_comb begin
    acc_ce  = in_valid && op.legal;
    acc_d   = op.acc_mode ? (acc_q + prod) : prod;
    wen_d   = acc_ce && op.write_rd;
    ill_d   = in_valid && !op.legal;
    wdata_d = op.hi_sel ? acc_d[AW-1:XLEN] : acc_d[XLEN-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_ce) begin
      acc_q <= acc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en   <= 1'b0;
      illegal <= 1'b0;
    end else begin
      wr_en   <= wen_d;
      illegal <= ill_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx  <= '0;
      wr_data <= '0;
    end else if (wen_d) begin
      wr_idx  <= rd;
      wr_data <= wdata_d;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/mdu_top.sv
module mdu_top
  import mdu_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned IDXW = 5,
  localparam int unsigned AW  = 2 * XLEN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic            wr_en,
  output logic [IDXW-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data,
  output logic            illegal,
  output logic [XLEN-1:0] acc_hi,
  output logic [XLEN-1:0] acc_lo
);
  mdu_op_t         op;
  logic [IDXW-1:0] rd;
  logic [AW-1:0]   prod;
  logic [AW-1:0]   acc;

  mdu_decode #(.IDXW(IDXW)) u_dec (
    .instr (instr),
    .op    (op),
    .rd    (rd)
  );

  mdu_mult #(.XLEN(XLEN)) u_mul (
    .a     (src_a),
    .b     (src_b),
    .unsgn (op.unsgn),
    .prod  (prod)
  );

  mdu_acc #(.XLEN(XLEN), .IDXW(IDXW)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op       (op),
    .rd       (rd),
    .prod     (prod),
    .acc      (acc),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .illegal  (illegal)
  );

  assign acc_hi = acc[AW-1:XLEN];
  assign acc_lo = acc[XLEN-1:0];
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            wr_en,
  input logic [XLEN-1:0] wr_data,
  input logic            illegal,
  input logic [XLEN-1:0] acc_hi,
  input logic [XLEN-1:0] acc_lo
);
  // R7
  wr_vs_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, illegal}));

  // R7
  illegal_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $stable({acc_hi, acc_lo}));

  // R10
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!wr_en && !illegal && $stable({acc_hi, acc_lo})));

  // R2
  wdata_is_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data == acc_hi || wr_data == acc_lo));

  // R9
  wr_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(in_valid));
endmodule

bind mdu_top mdu_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/mdu_top_tb_top.sv
module mdu_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] instr, src_a, src_b;
  logic        wr_en, illegal;
  logic [4:0]  wr_idx;
  logic [31:0] wr_data, acc_hi, acc_lo;

  int n_cmp = 0;
  int n_bad = 0;

  logic [63:0] m_acc;
  logic        m_wen, m_ill;
  logic [4:0]  m_idx;
  logic [31:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdu_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .illegal(illegal), .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  function automatic logic [31:0] mk(input logic [4:0] rd, input logic [4:0] sub);
    return {6'b000000, 5'd3, 5'd4, rd, sub, 6'b101000};
  endfunction

  function automatic logic [63:0] product(input logic [31:0] a, b, input logic uns);
    longint sa, sb;
    if (uns) return {32'b0, a} * {32'b0, b};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    return 64'(sa * sb);
  endfunction

  task automatic cmp(input string tag, input string what, input logic [63:0] act, exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    cmp(tag, "acc", {acc_hi, acc_lo}, m_acc);
    cmp(tag, "wr_en", 64'(wr_en), 64'(m_wen));
    cmp(tag, "illegal", 64'(illegal), 64'(m_ill));
    if (m_wen) begin
      cmp(tag, "wr_idx", 64'(wr_idx), 64'(m_idx));
      cmp(tag, "wr_data", 64'(wr_data), 64'(m_data));
    end
  endtask

  task automatic step(input logic v, input logic [31:0] ins, a, b, input string tag);
    logic ok, rep, uns, hi, wr;
    logic [63:0] p;
    in_valid = v; instr = ins; src_a = a; src_b = b;
    m_wen = 1'b0; m_ill = 1'b0;
    ok = 1'b1; rep = 1'b0; uns = 1'b0; hi = 1'b0; wr = 1'b1;
    if (v) begin
      if (ins[31:26] != 6'b0 || ins[5:0] != 6'b101000) ok = 1'b0;
      else case (ins[10:6])
        5'b00100: rep = 1'b1;
        5'b00101: begin rep = 1'b1; uns = 1'b1; end
        5'b01100: begin rep = 1'b1; hi = 1'b1; end
        5'b01101: begin rep = 1'b1; hi = 1'b1; uns = 1'b1; end
        5'b00010: ;
        5'b00011: uns = 1'b1;
        5'b01010: hi = 1'b1;
        5'b01011: begin hi = 1'b1; uns = 1'b1; end
        5'b00000: if (ins[15:11] == 5'd0) wr = 1'b0; else ok = 1'b0;
        default:  ok = 1'b0;
      endcase
      if (!ok) m_ill = 1'b1;
      else begin
        p = product(a, b, uns);
        m_acc = rep ? p : m_acc + p;
        m_wen = wr;
        m_idx = ins[15:11];
        m_data = hi ? m_acc[63:32] : m_acc[31:0];
      end
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [4:0] subs [10];
    subs = '{5'b00100, 5'b00101, 5'b01100, 5'b01101, 5'b00010,
             5'b00011, 5'b01010, 5'b01011, 5'b00000, 5'b00110};
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0;
    m_acc = '0; m_wen = 1'b0; m_ill = 1'b0; m_idx = '0; m_data = '0;
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    step(1'b0, 32'h0, 32'h0, 32'h0, "R1");

    step(1'b1, mk(5'd7, 5'b00100), 32'hFFFF_FFFD, 32'd7, "R2");
    step(1'b1, mk(5'd8, 5'b00101), 32'hFFFF_FFFF, 32'd2, "R2");
    step(1'b1, mk(5'd9, 5'b01100), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    step(1'b1, mk(5'd10, 5'b01101), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3");
    step(1'b1, mk(5'd11, 5'b01100), 32'h8000_0000, 32'd3, "R3");
    step(1'b1, mk(5'd12, 5'b00010), 32'hFFFF_FFFF, 32'd5, "R4");
    step(1'b1, mk(5'd13, 5'b00011), 32'h1234_5678, 32'h9ABC_DEF0, "R4");
    step(1'b1, mk(5'd14, 5'b01010), 32'h8000_0000, 32'h8000_0000, "R5");
    step(1'b1, mk(5'd15, 5'b01011), 32'hDEAD_BEEF, 32'h0000_1000, "R5");
    step(1'b1, mk(5'd0, 5'b00000), 32'hFFFF_FFF0, 32'd9, "R6");
    step(1'b1, mk(5'd0, 5'b00000), 32'd100, 32'd100, "R6");

    step(1'b1, mk(5'd3, 5'b00010) | 32'h0400_0000, 32'd5, 32'd5, "R7");
    step(1'b1, mk(5'd3, 5'b00010) ^ 32'h0000_0001, 32'd5, 32'd5, "R7");
    step(1'b1, mk(5'd3, 5'b00110), 32'd5, 32'd5, "R7");
    step(1'b1, mk(5'd3, 5'b10100), 32'd5, 32'd5, "R7");
    step(1'b1, mk(5'd5, 5'b00000), 32'd5, 32'd5, "R7");
    step(1'b1, mk(5'd3, 5'b01000), 32'd5, 32'd5, "R7");
    step(1'b1, mk(5'd3, 5'b00001), 32'd5, 32'd5, "R7");

    step(1'b1, mk(5'd1, 5'b00101), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    for (int i = 0; i < 4; i++)
      step(1'b1, mk(5'd2, 5'b01011), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");
    step(1'b1, mk(5'd2, 5'b00010), 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8");

    step(1'b1, mk(5'd0, 5'b00000), 32'd4, 32'd4, "R10");
    step(1'b0, mk(5'd4, 5'b00100), 32'd77, 32'd77, "R10");
    step(1'b0, 32'hFFFF_FFFF, 32'd1, 32'd1, "R10");

    for (int i = 0; i < 400; i++) begin
      logic [4:0] s;
      logic [4:0] r;
      s = subs[$urandom_range(9, 0)];
      r = (s == 5'b00000 && $urandom_range(3, 0) != 0) ? 5'd0 : 5'($urandom);
      step(1'b1, mk(r, s), $urandom, $urandom, "R9");
    end
    for (int i = 0; i < 300; i++) begin
      logic [4:0] s;
      s = subs[$urandom_range(9, 0)];
      step(1'($urandom_range(1, 0)), mk(5'($urandom), s), $urandom, $urandom, "R10");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule